// File: doc/BRIEF.md
# Programmable Sector Trigger Reduction

This block reduces a wide vector of per-channel hit flags, one flag per front-end channel and sampled on the bunch clock, to a small set of regional trigger bits. Each channel carries a programmable route that names one sector output, and an enable flag. A sector bit is the logical OR of the hits on all enabled channels routed to it. The sector bits are registered, so each one follows the hits sampled one clock earlier.

After reset the routing splits the channels into equal contiguous blocks, and every channel is enabled. Configuration uses a single-cycle write port that carries a strobe, a channel address, a sector index and an enable bit. A write reprograms one channel at a clock edge. The hits sampled at that same edge are still combined under the old routing, so the outputs never see a half-applied change.

Top module: `sector_trigger_or`

## Requirements
- R1: While reset is asserted, every bit of `sector_o` is 0.
- R2: For sector s, `sector_o[s]` after a rising edge equals the OR of `hit_i[c]` sampled at that edge, taken over all channels c that are enabled and routed to s. This gives a latency of one clock.
- R3: After reset, channel c (counting from 0) is enabled and routed to sector floor(c*N_SEC/N_CH). With the defaults, channels 0–15 go to sector 0, channels 16–31 to sector 1, and so on up to channels 112–127 to sector 7.
- R4: When `cfg_we` is 1 at an edge, channel `cfg_addr` takes `cfg_sector` as its route and `cfg_enable` as its enable. The new setting first applies to hits sampled at the following edge. Hits sampled at the write edge still use the previous setting.
- R5: A channel written with `cfg_enable`=0 has no effect on any sector output, whatever its route.
- R6: Several channels may share one sector, and their hits are ORed. A sector with no enabled channel routed to it stays 0.
- R7: A write changes only the addressed channel. The routing and enable of every other channel are unchanged.
- R8: With no hits sampled, all sector outputs are 0 on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_i | input | N_CH (128) | Per-channel hit flags |
| cfg_we | input | 1 | Routing write strobe |
| cfg_addr | input | log2(N_CH) (7) | Channel to reprogram |
| cfg_sector | input | log2(N_SEC) (3) | New sector index for that channel |
| cfg_enable | input | 1 | New enable for that channel |
| sector_o | output | N_SEC (8) | Registered sector trigger bits |

## Verification
The hardest case to reach from the ports is a write and a hit on the same channel in the same cycle. Here the output must reflect the old route, and only the next cycle may show the new one. The stimulus drives that collision on purpose. It then hits a neighbouring channel to show that the write stayed local.

Emptying one sector also takes a series of writes. The bench reroutes every channel of one default block to another sector, then floods all channels with hits. The emptied sector must stay at 0 while the other sector collects the rerouted hits. Random dense and sparse hit patterns then run together with random writes. They are compared every cycle against a behavioural routing table kept in the bench.

// File: rtl/sectr_pkg.sv
package sectr_pkg;

  // Sector a channel belongs to after reset: equal contiguous blocks.
  function automatic int unsigned home_sector(input int unsigned ch,
                                              input int unsigned n_ch,
                                              input int unsigned n_sec);
    return (ch * n_sec) / n_ch;
  endfunction

endpackage

// File: rtl/sector_map_regs.sv
module sector_map_regs #(
  parameter int N_CH  = 128,
  parameter int N_SEC = 8,
  localparam int SEC_W  = $clog2(N_SEC),
  localparam int ADDR_W = $clog2(N_CH)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_we,
  input  logic [ADDR_W-1:0]           cfg_addr,
  input  logic [SEC_W-1:0]            cfg_sector,
  input  logic                        cfg_enable,
  output logic [N_CH-1:0][SEC_W-1:0]  map_sec_o,
  output logic [N_CH-1:0]             map_en_o
);
  import sectr_pkg::*;

  logic [N_CH-1:0][SEC_W-1:0] sec_q;
  logic [N_CH-1:0]            en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < N_CH; c++) begin
        sec_q[c] <= SEC_W'(home_sector(c, N_CH, N_SEC));
        en_q[c]  <= 1'b1;
      end
    end else if (cfg_we) begin
      sec_q[cfg_addr] <= cfg_sector;
      en_q[cfg_addr]  <= cfg_enable;
    end
  end

  assign map_sec_o = sec_q;
  assign map_en_o  = en_q;

  assert_write_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (sec_q[$past(cfg_addr)] == $past(cfg_sector)) &&
               (en_q[$past(cfg_addr)] == $past(cfg_enable)));

  for (genvar g = 0; g < N_CH; g++) begin : g_local
    assert_write_local_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_we || cfg_addr != ADDR_W'(g)) |=> ($stable(sec_q[g]) && $stable(en_q[g])));
  end

endmodule

// File: rtl/sector_or_net.sv
module sector_or_net #(
  parameter int N_CH  = 128,
  parameter int N_SEC = 8,
  localparam int SEC_W = $clog2(N_SEC)
) (
  input  logic [N_CH-1:0]             hit_i,
  input  logic [N_CH-1:0][SEC_W-1:0]  map_sec_i,
  input  logic [N_CH-1:0]             map_en_i,
  output logic [N_SEC-1:0]            sector_raw_o
);
  logic [N_CH-1:0] live_hits;
  assign live_hits = hit_i & map_en_i;

  for (genvar s = 0; s < N_SEC; s++) begin : g_sec
    logic [N_CH-1:0] member;
    always_comb begin
      for (int c = 0; c < N_CH; c++)
        member[c] = (map_sec_i[c] == SEC_W'(s));
    end
    assign sector_raw_o[s] = |(live_hits & member);
  end

endmodule

// File: rtl/sector_out_reg.sv
module sector_out_reg #(
  parameter int N_SEC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SEC-1:0] d_i,
  output logic [N_SEC-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= d_i;
  end
endmodule

// File: rtl/sector_trigger_or.sv
module sector_trigger_or #(
  parameter int N_CH  = 128,
  parameter int N_SEC = 8,
  localparam int SEC_W  = $clog2(N_SEC),
  localparam int ADDR_W = $clog2(N_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_CH-1:0]   hit_i,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [SEC_W-1:0]  cfg_sector,
  input  logic              cfg_enable,
  output logic [N_SEC-1:0]  sector_o
);
  logic [N_CH-1:0][SEC_W-1:0] map_sec;
  logic [N_CH-1:0]            map_en;
  logic [N_SEC-1:0]           sector_raw;

  sector_map_regs #(.N_CH(N_CH), .N_SEC(N_SEC)) u_map (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_sector(cfg_sector), .cfg_enable(cfg_enable),
    .map_sec_o(map_sec), .map_en_o(map_en));

  sector_or_net #(.N_CH(N_CH), .N_SEC(N_SEC)) u_or (
    .hit_i(hit_i), .map_sec_i(map_sec), .map_en_i(map_en),
    .sector_raw_o(sector_raw));

  sector_out_reg #(.N_SEC(N_SEC)) u_out (
    .clk(clk), .rst_n(rst_n), .d_i(sector_raw), .q_o(sector_o));

  assert_hit_origin_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|sector_o) |-> $past(|hit_i));

  assert_disabled_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((hit_i & map_en) == '0) |=> (sector_o == '0));

  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_i == '0) |=> (sector_o == '0));

endmodule

// File: tb/sector_trigger_or_bench.sv
module sector_trigger_or_bench;
  localparam int NC = 128;
  localparam int NS = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NC-1:0] hit = '0;
  logic          cfg_we = 1'b0;
  logic [6:0]    cfg_addr = '0;
  logic [2:0]    cfg_sector = '0;
  logic          cfg_enable = 1'b0;
  logic [NS-1:0] sector_o;

  int checks = 0;
  int errors = 0;
  int ref_sec[NC];
  bit ref_en[NC];
  logic [NS-1:0] expv;

  always #5 clk = ~clk;

  sector_trigger_or u_sector_trigger_or (
    .clk(clk), .rst_n(rst_n), .hit_i(hit), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_sector(cfg_sector), .cfg_enable(cfg_enable), .sector_o(sector_o));

  task automatic check(input bit ok, input string tag, input logic [NS-1:0] act,
                       input logic [NS-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // One cycle: drive at negedge, model at posedge, compare at next negedge.
  task automatic step(input logic [NC-1:0] h, input bit we, input int a,
                      input int s, input bit e, input string tag);
    hit = h; cfg_we = we; cfg_addr = a[6:0]; cfg_sector = s[2:0]; cfg_enable = e;
    @(posedge clk);
    expv = '0;
    for (int c = 0; c < NC; c++)
      if (ref_en[c] && h[c]) expv[ref_sec[c]] = 1'b1;
    if (we) begin ref_sec[a] = s; ref_en[a] = e; end
    @(negedge clk);
    check(sector_o == expv, tag, sector_o, expv);
  endtask

  function automatic logic [NC-1:0] onehot(input int c);
    return NC'(1) << c;
  endfunction

  function automatic logic [NC-1:0] rnd_vec();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // Reference default routing: count channels into blocks of NC/NS.
    begin
      int blk = 0, cnt = 0;
      for (int c = 0; c < NC; c++) begin
        ref_sec[c] = blk; ref_en[c] = 1'b1; cnt++;
        if (cnt == NC / NS) begin cnt = 0; blk++; end
      end
    end
    repeat (3) @(negedge clk);
    check(sector_o == '0, "R1 reset", sector_o, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 idle
    step('0, 0, 0, 0, 0, "R8 idle");
    step('0, 0, 0, 0, 0, "R8 idle");

    // R3 default grouping, walking single hit
    for (int c = 0; c < NC; c++) step(onehot(c), 0, 0, 0, 0, "R3 default map");
    step(rnd_vec(), 0, 0, 0, 0, "R2 dense pattern");
    step('1, 0, 0, 0, 0, "R2 all hits");

    // R4 collision: write ch5 -> sector 7 while ch5 is hit
    step(onehot(5), 1, 5, 7, 1, "R4 old route at write edge");
    step(onehot(5), 0, 0, 0, 0, "R4 new route next cycle");
    step(onehot(4), 0, 0, 0, 0, "R7 neighbour unchanged");
    step(onehot(6), 0, 0, 0, 0, "R7 neighbour unchanged");

    // R5 disabled channel
    step('0, 1, 20, 3, 0, "R5 disable write");
    step(onehot(20), 0, 0, 0, 0, "R5 disabled hit ignored");
    step(onehot(20) | onehot(21), 0, 0, 0, 0, "R5 enabled sibling still seen");

    // R6 empty sector 6 by rerouting its block to sector 2
    for (int c = 96; c < 112; c++) step('0, 1, c, 2, 1, "R6 reroute");
    step('1, 0, 0, 0, 0, "R6 empty sector stays low");
    step(onehot(100), 0, 0, 0, 0, "R6 rerouted hit on shared sector");

    // R2 random hits with random writes
    for (int i = 0; i < 300; i++) begin
      logic [NC-1:0] h;
      h = (i % 2 == 0) ? (rnd_vec() & rnd_vec() & rnd_vec() & rnd_vec()) : rnd_vec();
      step(h, ($urandom % 3) == 0, $urandom % NC, $urandom % NS,
           ($urandom % 4) != 0, "R2 random");
    end
    step('0, 0, 0, 0, 0, "R8 idle after traffic");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule